// File: doc/BRIEF.md
# Time-of-Day Counter with Atomic Adjust

This block keeps a precision time of day as three fields: seconds, nanoseconds and a binary fraction of a nanosecond. While running, it adds a programmable fixed-point step to the nanosecond and fraction pair on every clock cycle. When the nanosecond field reaches a programmable one-second threshold it wraps, keeping the excess, and the seconds field counts up.

Software drives the block through a simple register write port and a combinational read port. It can stage an absolute time, or a nanosecond offset, in holding registers. It then writes a three-bit operation code into the configuration word. The chosen operation is applied to all time fields together on the next clock edge, and the code then clears itself. A tick that falls in the same cycle is folded into the result, so no step is lost.

An external timestamp input passes through a two-flop synchroniser. On the selected edge of this input, the block latches the current {seconds, nanoseconds}.

Top module: `tod_counter`

## Requirements
- R1: After reset the time fields, increment and configuration read as zero and the threshold reads 1,000,000,000. While the run bit (configuration bit 0) is clear and no operation is pending, the time does not change.
- R2: While running, each cycle adds the 64-bit increment register (whole nanoseconds in bits 63:32, fraction in bits 31:0) to the {ns, fraction} pair. A carry out of the fraction goes into the nanoseconds.
- R3: When the new nanosecond sum is equal to or above the threshold, the nanoseconds become the sum minus the threshold and the seconds count up by one. A sum one below the threshold does not wrap.
- R4: The operation field sits at configuration bits 28:26 and takes effect on the clock edge after it is written. It then reads back as zero. A tick in that cycle is applied on top of the operation's result. Codes other than 1, 3 and 4 change nothing.
- R5: Code 1 (load) sets seconds to the staged seconds, fraction to the staged fraction, and nanoseconds to the staged nanoseconds minus the staged current-boundary value. It also sets the threshold to the staged next-boundary value minus the staged current-boundary value.
- R6: Code 3 (advance) adds the staged nanoseconds to the nanosecond field, carrying into seconds at the threshold. Afterwards the staged fraction register reads zero.
- R7: Code 4 (retard) subtracts the staged nanoseconds. When the field is too small, it borrows one second and adds the threshold.
- R8: A retard that would take the total time below zero leaves all time fields at zero.
- R9: With capture enabled (configuration bit 8), a rising edge of the timestamp input is captured when bit 9 is 0, and a falling edge when bit 9 is 1. The capture holds {seconds, ns} in bits 63:32 and 31:0. The captured value is the time visible two edges after the input changes, and it is kept until the next qualifying edge. With capture disabled, or on the other edge, nothing is captured.
- R10: The register addresses are 0 configuration, 1 increment, 2 threshold, 3 staged ns, 4 staged fraction, 5 staged seconds, 6 staged current boundary, 7 staged next boundary, 8 {ns, fraction}, 9 seconds and 10 capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Combinational read data |
| ts_in | input | 1 | Asynchronous timestamp event input |
| tod_sec | output | 32 | Current seconds |
| tod_ns | output | 32 | Current nanoseconds |
| cap_pulse | output | 1 | High in the cycle a capture is taken |

## Verification
A corrupted accumulator or a missed wrap is visible on tod_sec and tod_ns on the very next edge. The tests therefore freeze the counter after a known number of ticks and compare the whole {ns, fraction} word, which also exposes a fraction carry that was dropped. An operation that is applied late, twice, or without the folded tick moves the time by exactly one increment, so the fold is checked with a single tick. A wrong synchroniser depth shifts the captured nanoseconds by one increment per extra stage. The bench catches this by comparing the capture against the time read two edges after the input changes.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 32;
  localparam int FRAC_W = 32;
  localparam int INCR_W = NS_W + FRAC_W;
  localparam logic [NS_W-1:0] ONE_SEC_NS = 32'd1_000_000_000;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SET  = 3'd1,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4
  } op_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;

  localparam logic [3:0] A_CFG   = 4'd0;
  localparam logic [3:0] A_INCR  = 4'd1;
  localparam logic [3:0] A_THR   = 4'd2;
  localparam logic [3:0] A_SNS   = 4'd3;
  localparam logic [3:0] A_SFRAC = 4'd4;
  localparam logic [3:0] A_SSEC  = 4'd5;
  localparam logic [3:0] A_SCUR  = 4'd6;
  localparam logic [3:0] A_SNXT  = 4'd7;
  localparam logic [3:0] A_TNS   = 4'd8;
  localparam logic [3:0] A_TSEC  = 4'd9;
  localparam logic [3:0] A_CAP   = 4'd10;

  localparam int CFG_RUN    = 0;
  localparam int CFG_CAP_EN = 8;
  localparam int CFG_CAP_FE = 9;
  localparam int CFG_OP_LO  = 26;

  // One accumulation step with wrap that keeps the excess.
  function automatic tod_t tod_tick(input tod_t t, input logic [INCR_W-1:0] incr,
                                    input logic [NS_W-1:0] thr);
    logic [INCR_W:0] sum;
    logic [NS_W:0]   hi;
    tod_t r;
    sum    = {1'b0, t.ns, t.frac} + {1'b0, incr};
    hi     = sum[INCR_W:FRAC_W];
    r.frac = sum[FRAC_W-1:0];
    if (hi >= {1'b0, thr}) begin
      r.ns  = NS_W'(hi - {1'b0, thr});
      r.sec = t.sec + SEC_W'(1);
    end else begin
      r.ns  = hi[NS_W-1:0];
      r.sec = t.sec;
    end
    return r;
  endfunction

  // Forward nanosecond adjust with carry into seconds.
  function automatic tod_t tod_inc(input tod_t t, input logic [NS_W-1:0] d,
                                   input logic [NS_W-1:0] thr);
    logic [NS_W:0] n;
    tod_t r;
    r = t;
    n = {1'b0, t.ns} + {1'b0, d};
    if (n >= {1'b0, thr}) begin
      r.ns  = NS_W'(n - {1'b0, thr});
      r.sec = t.sec + SEC_W'(1);
    end else begin
      r.ns = n[NS_W-1:0];
    end
    return r;
  endfunction

  // Backward nanosecond adjust with borrow; floors at zero time.
  function automatic tod_t tod_dec(input tod_t t, input logic [NS_W-1:0] d,
                                   input logic [NS_W-1:0] thr);
    tod_t r;
    r = t;
    if (t.ns >= d) begin
      r.ns = t.ns - d;
    end else if (t.sec != '0) begin
      r.sec = t.sec - SEC_W'(1);
      r.ns  = t.ns + (thr - d);
    end else begin
      r = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
  import tod_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cfg_wr,
  output logic              thr_wr,
  output logic              run,
  output logic              cap_en,
  output logic              cap_fall,
  output logic [2:0]        op,
  output logic [INCR_W-1:0] incr,
  output logic [NS_W-1:0]   stg_ns,
  output logic [FRAC_W-1:0] stg_frac,
  output logic [SEC_W-1:0]  stg_sec,
  output logic [NS_W-1:0]   stg_cur,
  output logic [NS_W-1:0]   stg_nxt
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] target);
    return wr_en && (a == ADDR_W'(target));
  endfunction

  logic adj_op;
  assign cfg_wr = hit(wr_addr, A_CFG);
  assign thr_wr = hit(wr_addr, A_THR);
  assign adj_op = (op == OP_INC) || (op == OP_DEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cap_en   <= 1'b0;
      cap_fall <= 1'b0;
      op       <= '0;
      incr     <= '0;
      stg_ns   <= '0;
      stg_frac <= '0;
      stg_sec  <= '0;
      stg_cur  <= '0;
      stg_nxt  <= '0;
    end else begin
      if (cfg_wr) begin
        run      <= wr_data[CFG_RUN];
        cap_en   <= wr_data[CFG_CAP_EN];
        cap_fall <= wr_data[CFG_CAP_FE];
        op       <= wr_data[CFG_OP_LO +: 3];
      end else begin
        op <= '0;
      end
      if (hit(wr_addr, A_INCR)) incr    <= wr_data[INCR_W-1:0];
      if (hit(wr_addr, A_SNS))  stg_ns  <= wr_data[NS_W-1:0];
      if (hit(wr_addr, A_SSEC)) stg_sec <= wr_data[SEC_W-1:0];
      if (hit(wr_addr, A_SCUR)) stg_cur <= wr_data[NS_W-1:0];
      if (hit(wr_addr, A_SNXT)) stg_nxt <= wr_data[NS_W-1:0];
      if (hit(wr_addr, A_SFRAC))
        stg_frac <= wr_data[FRAC_W-1:0];
      else if (adj_op)
        stg_frac <= '0;
    end
  end
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [2:0]        op,
  input  logic [INCR_W-1:0] incr,
  input  logic [NS_W-1:0]   stg_ns,
  input  logic [FRAC_W-1:0] stg_frac,
  input  logic [SEC_W-1:0]  stg_sec,
  input  logic [NS_W-1:0]   stg_cur,
  input  logic [NS_W-1:0]   stg_nxt,
  input  logic              thr_wr,
  input  logic [NS_W-1:0]   thr_wdata,
  output tod_t              now,
  output logic [NS_W-1:0]   thr,
  output logic              roll_evt,
  output logic              sat_evt
);
  tod_t            base;
  tod_t            next_t;
  logic [NS_W-1:0] set_thr;
  logic [NS_W-1:0] tick_thr;

  assign set_thr  = stg_nxt - stg_cur;
  assign tick_thr = (op == OP_SET) ? set_thr : thr;

  always_comb begin
    case (op)
      OP_SET:  base = '{sec: stg_sec, ns: stg_ns - stg_cur, frac: stg_frac};
      OP_INC:  base = tod_inc(now, stg_ns, thr);
      OP_DEC:  base = tod_dec(now, stg_ns, thr);
      default: base = now;
    endcase
    next_t = run ? tod_tick(base, incr, tick_thr) : base;
  end

  assign roll_evt = run && (op == OP_NONE) && (next_t.sec != now.sec);
  assign sat_evt  = (op == OP_DEC) && (now.sec == '0) && (now.ns < stg_ns);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '0;
      thr <= ONE_SEC_NS;
    end else begin
      now <= next_t;
      if (op == OP_SET) thr <= set_thr;
      else if (thr_wr)  thr <= thr_wdata;
    end
  end
endmodule

// File: rtl/tod_capture.sv
`timescale 1ns/1ps
module tod_capture
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ts_in,
  input  logic                  cap_en,
  input  logic                  cap_fall,
  input  logic [SEC_W-1:0]      now_sec,
  input  logic [NS_W-1:0]       now_ns,
  output logic [SEC_W+NS_W-1:0] cap_val,
  output logic                  cap_evt
);
  logic [SYNC_STAGES-1:0] sync;
  logic                   prev;
  logic                   rise;
  logic                   fall;

  assign rise    = sync[SYNC_STAGES-1] & ~prev;
  assign fall    = ~sync[SYNC_STAGES-1] & prev;
  assign cap_evt = cap_en & (cap_fall ? fall : rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= '0;
      prev    <= 1'b0;
      cap_val <= '0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], ts_in};
      prev <= sync[SYNC_STAGES-1];
      if (cap_evt) cap_val <= {now_sec, now_ns};
    end
  end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ts_in,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic              cap_pulse
);
  logic              cfg_wr, thr_wr, run, cap_en, cap_fall;
  logic [2:0]        op;
  logic [INCR_W-1:0] incr;
  logic [NS_W-1:0]   stg_ns, stg_cur, stg_nxt, thr;
  logic [FRAC_W-1:0] stg_frac;
  logic [SEC_W-1:0]  stg_sec;
  tod_t              now;
  logic              roll_evt, sat_evt, cap_evt;
  logic [SEC_W+NS_W-1:0] cap_val;
  logic [DATA_W-1:0] cfg_word;

  tod_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .thr_wr(thr_wr), .run(run), .cap_en(cap_en), .cap_fall(cap_fall),
    .op(op), .incr(incr), .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
    .stg_cur(stg_cur), .stg_nxt(stg_nxt)
  );

  tod_accum u_accum (
    .clk(clk), .rst_n(rst_n), .run(run), .op(op), .incr(incr), .stg_ns(stg_ns),
    .stg_frac(stg_frac), .stg_sec(stg_sec), .stg_cur(stg_cur), .stg_nxt(stg_nxt),
    .thr_wr(thr_wr), .thr_wdata(wr_data[NS_W-1:0]), .now(now), .thr(thr),
    .roll_evt(roll_evt), .sat_evt(sat_evt)
  );

  tod_capture #(.SYNC_STAGES(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .cap_en(cap_en), .cap_fall(cap_fall),
    .now_sec(now.sec), .now_ns(now.ns), .cap_val(cap_val), .cap_evt(cap_evt)
  );

  assign tod_sec   = now.sec;
  assign tod_ns    = now.ns;
  assign cap_pulse = cap_evt;

  always_comb begin
    cfg_word                    = '0;
    cfg_word[CFG_RUN]           = run;
    cfg_word[CFG_CAP_EN]        = cap_en;
    cfg_word[CFG_CAP_FE]        = cap_fall;
    cfg_word[CFG_OP_LO +: 3]    = op;
    case (rd_addr)
      ADDR_W'(A_CFG):   rd_data = cfg_word;
      ADDR_W'(A_INCR):  rd_data = DATA_W'(incr);
      ADDR_W'(A_THR):   rd_data = DATA_W'(thr);
      ADDR_W'(A_SNS):   rd_data = DATA_W'(stg_ns);
      ADDR_W'(A_SFRAC): rd_data = DATA_W'(stg_frac);
      ADDR_W'(A_SSEC):  rd_data = DATA_W'(stg_sec);
      ADDR_W'(A_SCUR):  rd_data = DATA_W'(stg_cur);
      ADDR_W'(A_SNXT):  rd_data = DATA_W'(stg_nxt);
      ADDR_W'(A_TNS):   rd_data = DATA_W'({now.ns, now.frac});
      ADDR_W'(A_TSEC):  rd_data = DATA_W'(now.sec);
      ADDR_W'(A_CAP):   rd_data = DATA_W'(cap_val);
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        cfg_wr,
  input logic        run,
  input logic [2:0]  op,
  input logic [31:0] tod_sec,
  input logic [31:0] tod_ns,
  input logic        roll_evt,
  input logic        sat_evt,
  input logic        cap_evt,
  input logic [63:0] cap_val
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && op == 3'd0 && !wr_en) |=> ($stable(tod_sec) && $stable(tod_ns))); // R1

  AST_ROLL_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    roll_evt |=> (tod_sec == $past(tod_sec) + 32'd1)); // R3

  AST_OP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd0 && !cfg_wr) |=> (op == 3'd0)); // R4

  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> (tod_sec == 32'd0)); // R8

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val)); // R9
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_wr(cfg_wr), .run(run), .op(op),
  .tod_sec(tod_sec), .tod_ns(tod_ns), .roll_evt(roll_evt), .sat_evt(sat_evt),
  .cap_evt(cap_evt), .cap_val(cap_val)
);

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        ts_in = 1'b0;
  logic [31:0] tod_sec, tod_ns;
  logic        cap_pulse;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] cfg_base = '0;
  localparam logic [63:0] SEC1 = 64'd1_000_000_000;

  tod_counter u_tod_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ts_in(ts_in), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .cap_pulse(cap_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr_cfg(input logic run, input logic [2:0] op);
    wr(4'd0, cfg_base | {63'd0, run} | ({61'd0, op} << 26));
  endtask

  task automatic apply_op(input logic [2:0] op);
    wr_cfg(1'b0, op);
    @(negedge clk);
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] ns, input logic [31:0] fr);
    wr(4'd3, {32'd0, ns});
    wr(4'd4, {32'd0, fr});
    wr(4'd5, {32'd0, s});
    wr(4'd6, 64'd0);
    wr(4'd7, SEC1);
    apply_op(3'd1);
  endtask

  task automatic run_for(input int n);
    wr_cfg(1'b1, 3'd0);
    repeat (n - 1) @(negedge clk);
    wr_cfg(1'b0, 3'd0);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(4'd0, v); check("R1 cfg after reset", v, 64'd0);
    rd(4'd2, v); check("R1 threshold after reset", v, SEC1);
    rd(4'd1, v); check("R1 increment after reset", v, 64'd0);
    wr(4'd1, 64'h0000_0005_0000_0000);
    repeat (5) @(negedge clk);
    rd(4'd8, v); check("R1 time held while stopped", v, 64'd0);
    rd(4'd9, v); check("R10 seconds read address", v, 64'd0);
  endtask

  task automatic t_tick;
    logic [63:0] v;
    set_time(32'd0, 32'd0, 32'd0);
    wr(4'd1, 64'h0000_0002_8000_0000);
    run_for(4);
    rd(4'd8, v); check("R2 four 2.5ns steps", v, {32'd10, 32'd0});
    set_time(32'd0, 32'd0, 32'd0);
    run_for(3);
    rd(4'd8, v); check("R2 fraction carry three steps", v, {32'd7, 32'h8000_0000});
    repeat (3) @(negedge clk);
    rd(4'd8, v); check("R1 hold after stop", v, {32'd7, 32'h8000_0000});
  endtask

  task automatic t_roll;
    logic [63:0] v;
    wr(4'd1, {32'd10, 32'd0});
    set_time(32'd7, 32'd999_999_990, 32'd0);
    run_for(1);
    check("R3 exact wrap ns", {32'd0, tod_ns}, 64'd0);
    check("R3 exact wrap sec", {32'd0, tod_sec}, 64'd8);
    set_time(32'd7, 32'd999_999_989, 32'd0);
    run_for(1);
    check("R3 no early wrap", {tod_sec, tod_ns}, {32'd7, 32'd999_999_999});
    wr(4'd1, {32'd30, 32'd0});
    set_time(32'd7, 32'd999_999_990, 32'd0);
    run_for(1);
    check("R3 excess kept", {tod_sec, tod_ns}, {32'd8, 32'd20});
    rd(4'd9, v); check("R10 seconds register", v, 64'd8);
  endtask

  task automatic t_set;
    logic [63:0] v;
    wr(4'd3, 64'd2_500_000_000);
    wr(4'd4, 64'h1234);
    wr(4'd5, 64'd2);
    wr(4'd6, 64'd2_000_000_000);
    wr(4'd7, 64'd3_000_000_000);
    apply_op(3'd1);
    rd(4'd8, v); check("R5 load ns minus boundary", v, {32'd500_000_000, 32'h1234});
    rd(4'd9, v); check("R5 load seconds", v, 64'd2);
    rd(4'd2, v); check("R5 threshold from boundaries", v, SEC1);
    rd(4'd0, v); check("R4 opcode cleared", v & (64'd7 << 26), 64'd0);
    wr(4'd3, 64'd100); wr(4'd6, 64'd0); wr(4'd7, 64'd600);
    apply_op(3'd1);
    rd(4'd2, v); check("R5 short threshold", v, 64'd600);
    wr(4'd2, SEC1);
    rd(4'd2, v); check("R10 threshold write", v, SEC1);
    // fold: load with run set, stop on the apply edge
    wr(4'd1, {32'd5, 32'd0});
    wr(4'd3, 64'd100); wr(4'd4, 64'd0); wr(4'd5, 64'd3); wr(4'd7, SEC1);
    wr_cfg(1'b1, 3'd1);
    wr_cfg(1'b0, 3'd0);
    check("R4 tick folded into load", {tod_sec, tod_ns}, {32'd3, 32'd105});
    // unsupported code changes nothing
    apply_op(3'd2);
    check("R4 unknown code ignored", {tod_sec, tod_ns}, {32'd3, 32'd105});
    rd(4'd0, v); check("R4 unknown code cleared", v & (64'd7 << 26), 64'd0);
  endtask

  task automatic t_adjust;
    logic [63:0] v;
    set_time(32'd5, 32'd999_999_900, 32'd0);
    wr(4'd4, 64'hABCD);
    wr(4'd3, 64'd300);
    apply_op(3'd3);
    check("R6 advance with carry", {tod_sec, tod_ns}, {32'd6, 32'd200});
    rd(4'd4, v); check("R6 staged fraction zeroed", v, 64'd0);
    set_time(32'd5, 32'd1000, 32'd0);
    wr(4'd3, 64'd300);
    apply_op(3'd3);
    check("R6 advance no carry", {tod_sec, tod_ns}, {32'd5, 32'd1300});
    set_time(32'd5, 32'd100, 32'd0);
    wr(4'd3, 64'd300);
    apply_op(3'd4);
    check("R7 retard with borrow", {tod_sec, tod_ns}, {32'd4, 32'd999_999_800});
    set_time(32'd5, 32'd1000, 32'd0);
    wr(4'd3, 64'd300);
    apply_op(3'd4);
    check("R7 retard no borrow", {tod_sec, tod_ns}, {32'd5, 32'd700});
    set_time(32'd0, 32'd100, 32'h55);
    wr(4'd3, 64'd500);
    apply_op(3'd4);
    rd(4'd8, v); check("R8 floor ns and fraction", v, 64'd0);
    check("R8 floor seconds", {32'd0, tod_sec}, 64'd0);
  endtask

  task automatic t_capture;
    logic [63:0] v;
    logic [31:0] exp_ns;
    cfg_base = 64'h100;
    set_time(32'd9, 32'd1234, 32'd0);
    ts_in = 1'b1; repeat (4) @(negedge clk);
    rd(4'd10, v); check("R9 rising capture", v, {32'd9, 32'd1234});
    set_time(32'd9, 32'd5555, 32'd0);
    ts_in = 1'b0; repeat (4) @(negedge clk);
    rd(4'd10, v); check("R9 falling ignored in rising mode", v, {32'd9, 32'd1234});
    cfg_base = 64'h300;
    wr_cfg(1'b0, 3'd0);
    ts_in = 1'b1; repeat (4) @(negedge clk);
    rd(4'd10, v); check("R9 rising ignored in falling mode", v, {32'd9, 32'd1234});
    ts_in = 1'b0; repeat (4) @(negedge clk);
    rd(4'd10, v); check("R9 falling capture", v, {32'd9, 32'd5555});
    cfg_base = 64'h0;
    set_time(32'd9, 32'd777, 32'd0);
    ts_in = 1'b1; repeat (4) @(negedge clk);
    ts_in = 1'b0; repeat (4) @(negedge clk);
    rd(4'd10, v); check("R9 disabled no capture", v, {32'd9, 32'd5555});
    cfg_base = 64'h100;
    wr(4'd1, {32'd1, 32'd0});
    set_time(32'd1, 32'd0, 32'd0);
    wr_cfg(1'b1, 3'd0);
    ts_in = 1'b1;
    @(negedge clk); @(negedge clk);
    exp_ns = tod_ns;
    @(negedge clk);
    wr_cfg(1'b0, 3'd0);
    rd(4'd10, v); check("R9 two-stage latency", v, {32'd1, exp_ns});
    ts_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_roll();
    t_set();
    t_adjust();
    t_capture();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule